// File: doc/BRIEF.md
# Issue-Rate Datapath Width Controller

This block watches the number of instructions a core issues in each clock cycle and picks between two execution datapath widths. It adds up the issue counts over a fixed window of enabled cycles. At the end of each window it treats that total as the forecast for the next window. A low threshold and a high threshold compare against the total directly, with no division into a per-cycle rate. The gap between the two thresholds keeps the mode from toggling on small changes.

The controller is a two-state machine. In state `ST_WIDE` the core runs its full four-issue datapath. In state `ST_NARROW` it runs the two-issue datapath and asks for a faster clock. Three transitions exist:
- `SHRINK` goes from `ST_WIDE` to `ST_NARROW`.
- `GROW` goes from `ST_NARROW` to `ST_WIDE`.
- `HOLD` keeps the current state at any window boundary that lands in the band between the thresholds.

The speed-up the boost request asks for is a parameter in eighths, and the block presents it on its ratio output. The logic that resizes the pipeline, makes the clock and controls the supply acts on these outputs. That logic is not part of this block.

Top module: `dwc_ctrl`

## Requirements
- R1: After reset the block is in `ST_WIDE`. `dp_narrow` = 0, `boost_req` = 0, `mode_change` = 0, and `boost_ratio` = 8, which means 1.0 in eighths.
- R2: A window is `WIN_CYCLES` enabled cycles long. The issue counts of all those cycles, including the last one, are added into the window total. A new mode first shows on the outputs in the cycle after the last enabled cycle of the window, and never earlier.
- R3: The total register is wide enough for `MAX_ISSUE` (4) issues in every cycle of a window. A window of all-4 counts gives a total of 4·`WIN_CYCLES` with no wrap-around.
- R4: `SHRINK`: a window total strictly below `LO_COUNT` (1.6 per cycle, 16000 by default) selects `ST_NARROW`.
- R5: `GROW`: a window total greater than or equal to `HI_COUNT` (2.0 per cycle, 20000 by default) selects `ST_WIDE`. A narrow core that issues 2 in every cycle reaches this threshold exactly and therefore returns to wide.
- R6: `HOLD`: a total from `LO_COUNT` to `HI_COUNT`−1 inclusive leaves the mode unchanged, from either state.
- R7: In `ST_NARROW` the outputs are `dp_narrow` = 1, `boost_req` = 1 and `boost_ratio` = `BOOST_Q3` (clamped to 8..16). In `ST_WIDE` the outputs are `dp_narrow` = 0, `boost_req` = 0 and `boost_ratio` = 8.
- R8: `mode_change` is high for exactly one cycle, in the first cycle the new mode is visible. It stays low at boundaries that do not change the mode.
- R9: While `en` is low, the cycle position and the running total are frozen and `issue_cnt` is ignored. The window closes only after `WIN_CYCLES` enabled cycles.
- R10: The mode changes only at a window boundary, so each mode lasts at least one full window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Counting enable; when low, all window state is frozen |
| issue_cnt | input | $clog2(MAX_ISSUE+1) | Instructions issued this cycle, 0..MAX_ISSUE |
| dp_narrow | output | 1 | 1 selects the two-issue datapath |
| boost_req | output | 1 | Request for a faster core clock |
| boost_ratio | output | 5 | Requested clock ratio in eighths (8 = 1.0, 16 = 2.0) |
| mode_change | output | 1 | One-cycle pulse when the mode toggles |

## Verification
The assertions assume that `issue_cnt` never exceeds `MAX_ISSUE` in an enabled cycle. That assumption is what bounds the running total, and the bench only ever drives per-cycle counts from 0 to 4. The bench also assumes that the thresholds are ordered within the largest possible total. It runs a shortened window of 20 cycles with thresholds 32 and 40, which keeps that ordering. Stimulus changes only on falling edges and `en` is low between scenarios, so every window the bench builds holds exactly the enabled cycles it intends.

// File: rtl/dwc_pkg.sv
package dwc_pkg;

    typedef enum logic {
        ST_WIDE   = 1'b0,
        ST_NARROW = 1'b1
    } dw_state_e;

    localparam int RATIO_W = 5;
    localparam logic [RATIO_W-1:0] RATIO_UNITY = 5'd8;
    localparam logic [RATIO_W-1:0] RATIO_MAX   = 5'd16;

endpackage

// File: rtl/dwc_window_counter.sv
module dwc_window_counter #(
    parameter int WIN_CYCLES = 10000,
    parameter int MAX_ISSUE  = 4,
    parameter int IW         = 3,
    parameter int SW         = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [IW-1:0] issue_cnt,
    output logic          win_done,
    output logic [SW-1:0] win_sum
);
    localparam int CW = (WIN_CYCLES > 2) ? $clog2(WIN_CYCLES) : 1;
    localparam logic [CW-1:0] LAST_POS = CW'(WIN_CYCLES - 1);
    localparam logic [SW-1:0] ACC_BOUND = SW'((WIN_CYCLES - 1) * MAX_ISSUE);

    logic [CW-1:0] cyc_pos;
    logic [SW-1:0] acc;

    assign win_done = en && (cyc_pos == LAST_POS);
    assign win_sum  = acc + SW'(issue_cnt);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_pos <= '0;
            acc     <= '0;
        end else if (en) begin
            if (cyc_pos == LAST_POS) begin
                cyc_pos <= '0;
                acc     <= '0;
            end else begin
                cyc_pos <= cyc_pos + 1'b1;
                acc     <= win_sum;
            end
        end
    end

    // R3: input assumption that keeps the running total bounded
    a_r3_issue_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (issue_cnt <= IW'(MAX_ISSUE)));

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        acc <= ACC_BOUND);

    a_r2_pos_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_pos <= LAST_POS);

    a_r9_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(cyc_pos) && $stable(acc)));

endmodule

// File: rtl/dwc_mode_fsm.sv
module dwc_mode_fsm
    import dwc_pkg::*;
#(
    parameter int SW       = 16,
    parameter int LO_COUNT = 16000,
    parameter int HI_COUNT = 20000,
    parameter logic [RATIO_W-1:0] BOOST_CODE = 5'd12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               win_done,
    input  logic [SW-1:0]      win_sum,
    output logic               dp_narrow,
    output logic               boost_req,
    output logic [RATIO_W-1:0] boost_ratio,
    output logic               mode_change
);
    localparam logic [SW-1:0] LO_TH = SW'(LO_COUNT);
    localparam logic [SW-1:0] HI_TH = SW'(HI_COUNT);

    dw_state_e state, nxt;

    // next state: SHRINK, GROW or HOLD at a window boundary
    always_comb begin
        nxt = state;
        unique case (state)
            ST_WIDE: begin
                if (win_done && (win_sum < LO_TH)) nxt = ST_NARROW;
            end
            ST_NARROW: begin
                if (win_done && (win_sum >= HI_TH)) nxt = ST_WIDE;
            end
            default: nxt = ST_WIDE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_WIDE;
            mode_change <= 1'b0;
        end else begin
            state       <= nxt;
            mode_change <= (nxt != state);
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_NARROW: begin
                dp_narrow   = 1'b1;
                boost_req   = 1'b1;
                boost_ratio = BOOST_CODE;
            end
            default: begin
                dp_narrow   = 1'b0;
                boost_req   = 1'b0;
                boost_ratio = RATIO_UNITY;
            end
        endcase
    end

    a_r10_boundary_only: assert property (@(posedge clk) disable iff (!rst_n)
        !win_done |=> (state == $past(state)));

    a_r4_shrink: assert property (@(posedge clk) disable iff (!rst_n)
        (win_done && (win_sum < LO_TH)) |=> (state == ST_NARROW));

    a_r5_grow: assert property (@(posedge clk) disable iff (!rst_n)
        (win_done && (win_sum >= HI_TH)) |=> (state == ST_WIDE));

    a_r8_pulse_on_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        mode_change |-> (state != $past(state)));

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mode_change |=> !mode_change);

endmodule

// File: rtl/dwc_ctrl.sv
module dwc_ctrl
    import dwc_pkg::*;
#(
    parameter int WIN_CYCLES = 10000,
    parameter int MAX_ISSUE  = 4,
    parameter int LO_COUNT   = 16000,
    parameter int HI_COUNT   = 20000,
    parameter int BOOST_Q3   = 12,
    localparam int IW = $clog2(MAX_ISSUE + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [IW-1:0]      issue_cnt,
    output logic               dp_narrow,
    output logic               boost_req,
    output logic [RATIO_W-1:0] boost_ratio,
    output logic               mode_change
);
    localparam int SW = $clog2(WIN_CYCLES * MAX_ISSUE + 1);
    localparam int BOOST_CLAMP = (BOOST_Q3 < 8) ? 8 : ((BOOST_Q3 > 16) ? 16 : BOOST_Q3);
    localparam logic [RATIO_W-1:0] BOOST_CODE = RATIO_W'(BOOST_CLAMP);

    logic          win_done;
    logic [SW-1:0] win_sum;

    dwc_window_counter #(
        .WIN_CYCLES (WIN_CYCLES),
        .MAX_ISSUE  (MAX_ISSUE),
        .IW         (IW),
        .SW         (SW)
    ) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .issue_cnt (issue_cnt),
        .win_done  (win_done),
        .win_sum   (win_sum)
    );

    dwc_mode_fsm #(
        .SW         (SW),
        .LO_COUNT   (LO_COUNT),
        .HI_COUNT   (HI_COUNT),
        .BOOST_CODE (BOOST_CODE)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .win_done    (win_done),
        .win_sum     (win_sum),
        .dp_narrow   (dp_narrow),
        .boost_req   (boost_req),
        .boost_ratio (boost_ratio),
        .mode_change (mode_change)
    );

    // R7: boost request and narrow mode travel together
    a_r7_boost_tracks_mode: assert property (@(posedge clk) disable iff (!rst_n)
        boost_req == dp_narrow);

endmodule

// File: tb/dwc_ctrl_tb_top.sv
module dwc_ctrl_tb_top;
    localparam int WIN   = 20;
    localparam int LO    = 32;
    localparam int HI    = 40;
    localparam int BOOST = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [2:0] issue_cnt = '0;
    logic       dp_narrow, boost_req, mode_change;
    logic [4:0] boost_ratio;

    int vec  = 0;
    int miss = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    dwc_ctrl #(
        .WIN_CYCLES (WIN),
        .MAX_ISSUE  (4),
        .LO_COUNT   (LO),
        .HI_COUNT   (HI),
        .BOOST_Q3   (BOOST)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .issue_cnt   (issue_cnt),
        .dp_narrow   (dp_narrow),
        .boost_req   (boost_req),
        .boost_ratio (boost_ratio),
        .mode_change (mode_change)
    );

    task automatic chk(string req, int act, int exp);
        vec++;
        if (act != exp) begin
            miss++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic expect_mode(string req, bit narrow, bit chg);
        chk({req, " dp_narrow"}, int'(dp_narrow), int'(narrow));
        chk({req, " boost_req"}, int'(boost_req), int'(narrow));
        chk({req, " boost_ratio"}, int'(boost_ratio), narrow ? BOOST : 8);
        chk({req, " mode_change"}, int'(mode_change), int'(chg));
        if (chg) begin
            @(negedge clk);
            chk({req, " R8 pulse width"}, int'(mode_change), 0);
        end
    endtask

    task automatic run(int n, int v, bit e);
        for (int i = 0; i < n; i++) begin
            en = e;
            issue_cnt = 3'(v);
            @(negedge clk);
        end
        en = 1'b0;
        issue_cnt = '0;
    endtask

    // total = WIN*base + extra
    task automatic window(int base, int extra);
        for (int i = 0; i < WIN; i++) begin
            en = 1'b1;
            issue_cnt = 3'((i < extra) ? base + 1 : base);
            @(negedge clk);
        end
        en = 1'b0;
        issue_cnt = '0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_mode("R1 reset", 1'b0, 1'b0);
    endtask

    task automatic t_wide_hold_at_hi;
        window(2, 0);                       // total 40 = HI
        expect_mode("R5 wide stays at HI", 1'b0, 1'b0);
    endtask

    task automatic t_shrink;
        window(1, 11);                      // total 31 < LO
        expect_mode("R4 R7 R8 shrink", 1'b1, 1'b1);
    endtask

    task automatic t_band_narrow;
        window(1, 12);                      // total 32 = LO
        expect_mode("R6 narrow hold at LO", 1'b1, 1'b0);
        window(1, 19);                      // total 39
        expect_mode("R6 narrow hold at HI-1", 1'b1, 1'b0);
    endtask

    task automatic t_grow_saturated;
        window(2, 0);                       // 2 per cycle, total 40
        expect_mode("R5 grow at saturation", 1'b0, 1'b1);
    endtask

    task automatic t_band_wide;
        window(1, 12);
        expect_mode("R6 wide hold at LO", 1'b0, 1'b0);
        window(1, 19);
        expect_mode("R6 wide hold at HI-1", 1'b0, 1'b0);
    endtask

    task automatic t_boundary_timing;
        run(WIN - 1, 0, 1'b1);
        expect_mode("R2 R10 no early change", 1'b0, 1'b0);
        run(1, 0, 1'b1);
        expect_mode("R2 change after last cycle", 1'b1, 1'b1);
    endtask

    task automatic t_freeze;
        run(10, 4, 1'b1);
        run(30, 4, 1'b0);                   // ignored
        expect_mode("R9 disabled cycles ignored", 1'b1, 1'b0);
        run(9, 4, 1'b1);
        expect_mode("R9 R10 still mid-window", 1'b1, 1'b0);
        run(1, 4, 1'b1);                    // total 80
        expect_mode("R3 R9 full-rate window grows", 1'b0, 1'b1);
    endtask

    task automatic t_zero_then_full;
        window(0, 0);
        expect_mode("R4 zero window", 1'b1, 1'b1);
        window(4, 0);
        expect_mode("R3 all-four window", 1'b0, 1'b1);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_wide_hold_at_hi();
        t_shrink();
        t_band_narrow();
        t_grow_saturated();
        t_band_wide();
        t_boundary_timing();
        t_freeze();
        t_zero_then_full();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            vec++;
            miss++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
            $finish;
        end
    end

endmodule